// File: doc/BRIEF.md
# Sixteen-Line Cascaded Interrupt Controller

Two eight-input priority controllers are joined so that sixteen request lines share a single interrupt output toward a 16-bit processor. The second (slave) controller reports its own pending state into input 2 of the first (master) controller. Slave lines 8 to 15 therefore take that slot in the overall priority order, and external line 2 cannot be used.

A status decoder watches the processor's memory/IO and two cycle-status pins. It recognises an interrupt-acknowledge cycle when all three are low, and produces a single acknowledge strobe for each such cycle. The master resolves the winning line on that strobe and sets its in-service bit. If the winner is a master line, the master returns the vector. If the winner is the cascade input, the master passes the strobe on to the slave, which then supplies the vector.

Each vector is a 5-bit programmable base followed by the 3-bit line index inside the responding controller. A small write-only register port sets the masks and bases and issues end-of-interrupt commands.

Top module: `irq_cascade_top`

## Requirements
- R1: An acknowledge is recognised only when stat_mio, stat_s0 and stat_s1 are all low. vec_valid is high for exactly one cycle, and that cycle follows the first clock edge that samples that status. Holding the status low longer gives no further pulse, and any other status combination gives none.
- R2: Among eligible requests, the order from highest to lowest is lines 0, 1, 8, 9, ..., 15, 3, 4, 5, 6, 7.
- R3: The vector byte holds the controller's base in bits [7:3] and the line index within that controller in bits [2:0]. Lines 0–7 use the master base and lines 8–15 use the slave base (line 8+k gives index k). Writing cfg_addr 2 (master) or 3 (slave) loads the base from cfg_wdata[7:3], and cfg_wdata[2:0] is ignored.
- R4: irq_req[2] has no effect on intr or on any vector.
- R5: cfg_addr 0 writes the master mask and cfg_addr 1 writes the slave mask, where bit k masks line k of that controller. A masked line neither raises intr nor wins an acknowledge. Masking master bit 2 blocks every slave line.
- R6: While a line is in service, requests of equal or lower priority do not raise intr, and a higher-priority request does. A slave line in service also puts master line 2 in service.
- R7: Writing cfg_addr 4 (master) or 5 (slave) clears the in-service bit indexed by cfg_wdata[2:0]. A slave line is released only once both the slave bit and master bit 2 are cleared.
- R8: An acknowledge with no eligible request returns the master base with index 7 and sets no in-service bit.
- R9: After reset, intr and vec_valid are low, all mask bits are set, both bases are zero and no line is in service.
- R10: intr follows the eligible request set in the same cycle, with no clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 16 | Request lines, level sensitive (bit 2 unused) |
| stat_mio | input | 1 | Processor memory/IO status |
| stat_s0 | input | 1 | Processor cycle status bit 0 |
| stat_s1 | input | 1 | Processor cycle status bit 1 |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register select |
| cfg_wdata | input | 8 | Register write data |
| intr | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector byte valid, one cycle per acknowledge |
| vec_out | output | 8 | Vector byte |

## Verification
The bench sweeps every single line and every ordered pair of usable lines. These cases catch a design that places the slave block in the wrong priority slot, lets the raw line-2 input compete, or returns a vector with the wrong base or index. Nested service is exercised in both controllers, including a slave EOI issued without the matching master EOI. A design that forgot to hold off equal-priority requests, or that released a slave line too early, would raise intr where it must stay low. The bench also drives every non-acknowledge status combination and a held acknowledge status, where a level-triggered decoder would return repeated vectors. A spurious acknowledge that wrongly marks line 7 in service would leave a later line-7 request silent.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;

    localparam int LINES   = 8;
    localparam int IDX_W   = $clog2(LINES);
    localparam int VEC_W   = 8;
    localparam int BASE_W  = VEC_W - IDX_W;
    localparam int CASC_AT = 2;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } pick_t;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [IDX_W-1:0]  line;
    } vec_t;

    typedef enum logic [2:0] {
        REG_MMASK = 3'd0,
        REG_SMASK = 3'd1,
        REG_MBASE = 3'd2,
        REG_SBASE = 3'd3,
        REG_MEOI  = 3'd4,
        REG_SEOI  = 3'd5
    } reg_sel_e;

    // lowest set index wins
    function automatic pick_t pick_first(input logic [LINES-1:0] v);
        pick_t r;
        r = '0;
        for (int i = LINES - 1; i >= 0; i--) begin
            if (v[i]) begin
                r.hit = 1'b1;
                r.idx = IDX_W'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/irq_ack_decode.sv
module irq_ack_decode (
    input  logic clk,
    input  logic rst,
    input  logic stat_mio,
    input  logic stat_s0,
    input  logic stat_s1,
    output logic ack_pulse
);
    logic ack_now;
    logic seen_q;

    assign ack_now   = !stat_mio && !stat_s0 && !stat_s1;
    assign ack_pulse = ack_now && !seen_q && !rst;

    always_ff @(posedge clk) begin
        if (rst) seen_q <= 1'b0;
        else     seen_q <= ack_now;
    end
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_cascade_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [2:0]           cfg_addr,
    input  logic [VEC_W-1:0]     cfg_wdata,
    output logic [LINES-1:0]     m_mask,
    output logic [LINES-1:0]     s_mask,
    output logic [BASE_W-1:0]    m_base,
    output logic [BASE_W-1:0]    s_base,
    output logic                 m_eoi,
    output logic                 s_eoi,
    output logic [IDX_W-1:0]     eoi_idx
);
    reg_sel_e sel;
    assign sel     = reg_sel_e'(cfg_addr);
    assign m_eoi   = cfg_we && (sel == REG_MEOI);
    assign s_eoi   = cfg_we && (sel == REG_SEOI);
    assign eoi_idx = cfg_wdata[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            m_mask <= '1;
            s_mask <= '1;
            m_base <= '0;
            s_base <= '0;
        end else if (cfg_we) begin
            case (sel)
                REG_MMASK: m_mask <= cfg_wdata[LINES-1:0];
                REG_SMASK: s_mask <= cfg_wdata[LINES-1:0];
                REG_MBASE: m_base <= cfg_wdata[VEC_W-1:IDX_W];
                REG_SBASE: s_base <= cfg_wdata[VEC_W-1:IDX_W];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/irq_pic8.sv
module irq_pic8
    import irq_cascade_pkg::*;
#(
    parameter bit IS_MASTER = 1'b1,
    parameter int CASC_LINE = CASC_AT
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [LINES-1:0]   req,
    input  logic [LINES-1:0]   mask,
    input  logic [BASE_W-1:0]  base,
    input  logic               eoi,
    input  logic [IDX_W-1:0]   eoi_idx,
    input  logic               ack_in,
    output logic               casc_ack,
    output logic               int_out,
    output logic               vec_vld,
    output vec_t               vec
);
    logic [LINES-1:0] isr;
    logic [LINES-1:0] pending;
    pick_t            top_req;
    pick_t            top_isr;
    logic             eligible;
    logic             to_slave;

    assign pending  = req & ~mask;
    assign top_req  = pick_first(pending);
    assign top_isr  = pick_first(isr);
    assign eligible = top_req.hit && (!top_isr.hit || (top_req.idx < top_isr.idx));
    assign int_out  = eligible;

    generate
        if (IS_MASTER) begin : g_casc
            assign to_slave = eligible && (top_req.idx == IDX_W'(CASC_LINE));
        end else begin : g_leaf
            assign to_slave = 1'b0;
        end
    endgenerate

    assign casc_ack = ack_in && to_slave;

    always_ff @(posedge clk) begin
        if (rst) begin
            isr     <= '0;
            vec_vld <= 1'b0;
            vec     <= '0;
        end else begin
            vec_vld <= 1'b0;
            if (eoi) isr[eoi_idx] <= 1'b0;
            if (ack_in) begin
                if (eligible) begin
                    isr[top_req.idx] <= 1'b1;
                    if (!to_slave) begin
                        vec_vld <= 1'b1;
                        vec     <= '{base: base, line: top_req.idx};
                    end
                end else begin
                    vec_vld <= 1'b1;
                    vec     <= '{base: base, line: IDX_W'(LINES - 1)};
                end
            end
        end
    end
endmodule

// File: rtl/irq_cascade_top.sv
module irq_cascade_top
    import irq_cascade_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [15:0] irq_req,
    input  logic        stat_mio,
    input  logic        stat_s0,
    input  logic        stat_s1,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_addr,
    input  logic [7:0]  cfg_wdata,
    output logic        intr,
    output logic        vec_valid,
    output logic [7:0]  vec_out
);
    logic [LINES-1:0]  m_mask, s_mask, m_req;
    logic [BASE_W-1:0] m_base, s_base;
    logic              m_eoi, s_eoi;
    logic [IDX_W-1:0]  eoi_idx;
    logic              ack_pulse, s_ack, s_int, m_int, m_vld, s_vld, s_unused_casc;
    vec_t              m_vec, s_vec;

    irq_ack_decode u_ack (
        .clk(clk), .rst(rst), .stat_mio(stat_mio), .stat_s0(stat_s0),
        .stat_s1(stat_s1), .ack_pulse(ack_pulse)
    );

    irq_cfg_regs u_regs (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .m_mask(m_mask), .s_mask(s_mask),
        .m_base(m_base), .s_base(s_base), .m_eoi(m_eoi), .s_eoi(s_eoi),
        .eoi_idx(eoi_idx)
    );

    // master input at the cascade slot comes from the slave, not the pin
    generate
        for (genvar i = 0; i < LINES; i++) begin : g_mreq
            if (i == CASC_AT) begin : g_c
                assign m_req[i] = s_int;
            end else begin : g_p
                assign m_req[i] = irq_req[i];
            end
        end
    endgenerate

    irq_pic8 #(.IS_MASTER(1'b1), .CASC_LINE(CASC_AT)) u_master (
        .clk(clk), .rst(rst), .req(m_req), .mask(m_mask), .base(m_base),
        .eoi(m_eoi), .eoi_idx(eoi_idx), .ack_in(ack_pulse),
        .casc_ack(s_ack), .int_out(m_int), .vec_vld(m_vld), .vec(m_vec)
    );

    irq_pic8 #(.IS_MASTER(1'b0), .CASC_LINE(CASC_AT)) u_slave (
        .clk(clk), .rst(rst), .req(irq_req[2*LINES-1:LINES]), .mask(s_mask),
        .base(s_base), .eoi(s_eoi), .eoi_idx(eoi_idx), .ack_in(s_ack),
        .casc_ack(s_unused_casc), .int_out(s_int), .vec_vld(s_vld), .vec(s_vec)
    );

    assign intr      = m_int;
    assign vec_valid = m_vld | s_vld;
    assign vec_out   = s_vld ? s_vec : m_vec;
endmodule

// File: rtl/irq_cascade_chk.sv
module irq_cascade_chk (
    input logic        clk,
    input logic        rst,
    input logic [15:0] irq_req,
    input logic        stat_mio,
    input logic        stat_s0,
    input logic        stat_s1,
    input logic        intr,
    input logic        vec_valid,
    input logic [7:0]  vec_out,
    input logic [4:0]  m_base,
    input logic [4:0]  s_base
);
    // R1
    ack_single_chk: assert property (@(posedge clk) disable iff (rst)
        vec_valid |=> !vec_valid);

    // R1
    ack_cause_chk: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> $past(!stat_mio && !stat_s0 && !stat_s1));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_req == 16'h0) |-> !intr);

    // R4
    line2_only_chk: assert property (@(posedge clk) disable iff (rst)
        ((irq_req & 16'hFFFB) == 16'h0) |-> !intr);

    // R3
    vec_base_chk: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> (vec_out[7:3] == $past(m_base) || vec_out[7:3] == $past(s_base)));
endmodule

bind irq_cascade_top irq_cascade_chk u_chk (
    .clk(clk), .rst(rst), .irq_req(irq_req), .stat_mio(stat_mio),
    .stat_s0(stat_s0), .stat_s1(stat_s1), .intr(intr), .vec_valid(vec_valid),
    .vec_out(vec_out), .m_base(m_base), .s_base(s_base)
);

// File: tb/irq_cascade_top_test.sv
module irq_cascade_top_test;
    localparam int CLK_P = 10;
    localparam logic [7:0] MB = 8'h20;   // master base 4
    localparam logic [7:0] SB = 8'h70;   // slave base 14

    logic        clk = 0, rst = 1;
    logic [15:0] irq_req = 0;
    logic        stat_mio = 1, stat_s0 = 1, stat_s1 = 1;
    logic        cfg_we = 0;
    logic [2:0]  cfg_addr = 0;
    logic [7:0]  cfg_wdata = 0;
    logic        intr, vec_valid;
    logic [7:0]  vec_out;
    int          n_chk = 0, n_bad = 0;
    bit          done = 0;

    irq_cascade_top uut (.*);

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk); cfg_we = 0;
    endtask

    task automatic ack(output logic v, output logic [7:0] vec);
        @(negedge clk); {stat_mio, stat_s0, stat_s1} = 3'b000;
        @(negedge clk); v = vec_valid; vec = vec_out;
        {stat_mio, stat_s0, stat_s1} = 3'b111;
    endtask

    function automatic int rank(input int l);
        if (l < 2) return l;
        if (l >= 8) return l - 6;
        return l + 8;
    endfunction

    function automatic logic [7:0] exp_vec(input int l);
        return (l < 8) ? (MB | 8'(l)) : (SB | 8'(l - 8));
    endfunction

    task automatic release_line(input int l);
        if (l >= 8) begin wr(3'd5, 8'(l - 8)); wr(3'd4, 8'd2); end
        else wr(3'd4, 8'(l));
    endtask

    task automatic serve(input string req, input int l);
        logic v; logic [7:0] vec;
        ack(v, vec);
        chk(req, v, 1);
        chk(req, vec, exp_vec(l));
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog actual=running expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic v; logic [7:0] vec; int cnt;
        irq_req = 16'hFFFF;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R9: masks set after reset, so nothing raises intr
        chk("R9 intr", intr, 0);
        chk("R9 vec_valid", vec_valid, 0);
        irq_req = 0;
        ack(v, vec);
        chk("R9 base zero", vec, 8'h07);
        wr(3'd0, 8'h00); wr(3'd1, 8'h00);
        wr(3'd2, MB | 8'h3); wr(3'd3, SB | 8'h5);   // R3 low bits ignored

        // R4: line 2 alone does nothing
        irq_req = 16'h0004; @(negedge clk);
        chk("R4 intr", intr, 0);
        ack(v, vec);
        chk("R4 vec", vec, MB | 8'h7);
        irq_req = 0;

        // R2 R3 R10: each single line
        for (int l = 0; l < 16; l++) begin
            if (l == 2) continue;
            irq_req = 16'(1) << l; @(negedge clk);
            chk("R10 intr", intr, 1);
            serve("R3 single", l);
            irq_req = 0; release_line(l);
        end

        // R2: every ordered pair
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                int w;
                if (a == 2 || b == 2 || a == b) continue;
                w = (rank(a) < rank(b)) ? a : b;
                irq_req = (16'(1) << a) | (16'(1) << b);
                serve("R2 pair", w);
                irq_req = 0; release_line(w);
            end
        end

        // R1: non-acknowledge status values
        irq_req = 16'h0008;
        for (int s = 1; s < 8; s++) begin
            cnt = 0;
            @(negedge clk); {stat_mio, stat_s0, stat_s1} = 3'(s);
            repeat (3) begin @(negedge clk); cnt += vec_valid; end
            {stat_mio, stat_s0, stat_s1} = 3'b111;
            chk("R1 non-ack status", cnt, 0);
        end
        // R1: held acknowledge gives one pulse
        cnt = 0;
        @(negedge clk); {stat_mio, stat_s0, stat_s1} = 3'b000;
        repeat (4) begin @(negedge clk); cnt += vec_valid; end
        {stat_mio, stat_s0, stat_s1} = 3'b111;
        chk("R1 held ack pulses", cnt, 1);
        irq_req = 0; release_line(3);

        // R5: masks
        wr(3'd0, 8'h10); irq_req = 16'h0010; @(negedge clk);
        chk("R5 masked master", intr, 0);
        irq_req = 16'h0050; serve("R5 masked loses", 6);
        irq_req = 0; release_line(6);
        wr(3'd0, 8'h04); irq_req = 16'h0200; @(negedge clk);
        chk("R5 cascade masked", intr, 0);
        wr(3'd0, 8'h00); wr(3'd1, 8'h02); @(negedge clk);
        chk("R5 slave masked", intr, 0);
        wr(3'd1, 8'h00); irq_req = 0;

        // R6: nesting in master
        irq_req = 16'h0020; serve("R6 line5", 5);
        irq_req = 16'h0060; @(negedge clk);
        chk("R6 lower held", intr, 0);
        irq_req = 16'h0061; @(negedge clk);
        chk("R6 higher passes", intr, 1);
        serve("R6 nested", 0);
        irq_req = 0; release_line(0); release_line(5);

        // R6 R7: nesting across cascade
        irq_req = 16'h0200; serve("R6 line9", 9);
        irq_req = 16'h1000; @(negedge clk);
        chk("R6 slave lower held", intr, 0);
        irq_req = 16'h0008; @(negedge clk);
        chk("R6 master lower held", intr, 0);
        irq_req = 16'h0002; @(negedge clk);
        chk("R6 line1 passes", intr, 1);
        irq_req = 0;
        wr(3'd5, 8'd1);
        irq_req = 16'h1000; @(negedge clk);
        chk("R7 master bit2 still held", intr, 0);
        wr(3'd4, 8'd2); @(negedge clk);
        chk("R7 released", intr, 1);
        serve("R7 line12", 12);
        irq_req = 0; release_line(12);

        // R8: spurious ack sets no in-service bit
        ack(v, vec);
        chk("R8 valid", v, 1);
        chk("R8 vec", vec, MB | 8'h7);
        irq_req = 16'h0080; @(negedge clk);
        chk("R8 line7 free", intr, 1);
        serve("R8 line7", 7);
        irq_req = 0; release_line(7);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule